// File: doc/BRIEF.md
# MDIO Management Frame Controller

This block is the station-management port of an Ethernet MAC. Host logic writes one 32-bit command word. That word holds a start code, an opcode, a 5-bit PHY address, a 5-bit register address, a turnaround field and 16 data bits. If the word is legal and the engine is idle, the block sends the full serial management frame on MDC/MDIO. The frame is a 32-bit preamble of ones followed by the 32 bits of the word. During the turnaround and data phases of a read, MDIO is released, and the 16 bits returned by the PHY are stored into the low half of the same command word.

An idle flag drops for the whole length of a transfer, and the host polls that flag to learn when the transfer is done. MDC is the system clock divided by `CLK_DIV`. MDIO changes only on the falling edge of MDC, and the PHY data is sampled on the rising edge. A port-enable input gates the whole port. While port-enable is low, no transfer starts, and a transfer already running is dropped at once.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: Out of reset, `idle`=1, `mdc`=0, `mdio_oe`=0 and `mgmt_word`=0. Whenever `idle` is high, `mdc` and `mdio_oe` are low.
- R2: A write (`wr_en`=1) is accepted when `port_en`=1, `idle`=1, bits 31:30 = 01 and bits 29:28 are 01 (write) or 10 (read). An accepted write stores the word, and `idle` is low in the next cycle.
- R3: Each frame is 64 MDC periods long. Periods 0..31 carry ones. Periods 32..45 carry word bits 31 down to 18: the start code, the opcode, the PHY address at bits 27:23 and the register address at bits 22:18.
- R4: In a write frame, periods 46 and 47 carry 1 then 0, whatever word bits 17:16 hold. Periods 48..63 carry word bits 15..0, MSB first. `mdio_oe` is high in all 64 periods.
- R5: In a read frame, `mdio_oe` is high in periods 0..45 and low in periods 46..63. The 16 bits sampled in periods 48..63, MSB first, replace `mgmt_word[15:0]` at completion. Bits 31:16 are kept.
- R6: The MDC period is `CLK_DIV` clocks, with the low half first: MDC rises `CLK_DIV/2` clocks after acceptance and falls `CLK_DIV` clocks after it. `mdio_o` changes only at a falling edge of MDC, or when the port is disabled.
- R7: `idle` returns high exactly 64*`CLK_DIV` cycles after the accepting edge.
- R8: A write while `idle` is low is ignored. Neither `mgmt_word` nor the running frame changes.
- R9: With `port_en`=0, writes are ignored: `idle` stays high, `mdc` stays low and `mgmt_word` is unchanged.
- R10: Clearing `port_en` during a frame ends it: one cycle later `idle`=1, `mdc`=0 and `mdio_oe`=0. A later frame runs normally.
- R11: A write with a start code other than 01, or with opcode 00 or 11, is ignored. No frame starts and `mgmt_word` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| port_en | input | 1 | Management port enable |
| wr_en | input | 1 | Command word write strobe |
| wr_data | input | 32 | Command word to write |
| mgmt_word | output | 32 | Current command word; holds read data after a read |
| idle | output | 1 | High when no frame is in progress |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input from the pad |

## Verification
`idle` falls one clock after the accepting edge, and the bench checks it at the first falling clock edge after the write. `idle` rises and read data appears in `mgmt_word` 64*`CLK_DIV` clocks after that edge, and the bench counts falling clock edges until `idle` rises and compares the count with that figure. Each MDIO bit is recorded half a clock after the MDC rising edge it belongs to, so both the period index and the data are fixed when it is read. The model PHY changes its bit half a clock after each MDC falling edge. Checks on MDC phase, the disable/abort case and ignored writes each look at the first falling clock edge after the edge that should act.

// File: rtl/mdio_mgmt_pkg.sv
// Package: shared field positions, opcodes and the legality check for the
// management command word. Assumes a clause-22 style 64-bit frame.
package mdio_mgmt_pkg;

    localparam int WORD_W     = 32;
    localparam int DATA_W     = 16;
    localparam int FRAME_BITS = 64;

    localparam int START_HI = 31;
    localparam int OP_HI    = 29;

    localparam logic [1:0] START_CODE = 2'b01;

    typedef enum logic [1:0] {
        OP_WRITE = 2'b01,
        OP_READ  = 2'b10
    } mdio_op_e;

    // True when the word carries a valid start code and opcode
    function automatic logic word_is_legal(input logic [WORD_W-1:0] w);
        logic [1:0] op;
        op = w[OP_HI -: 2];
        return (w[START_HI -: 2] == START_CODE) &&
               ((op == OP_WRITE) || (op == OP_READ));
    endfunction

endpackage

// File: rtl/mdio_mdc_gen.sv
// Module: MDC generator. It divides clk by CLK_DIV while run is high, low
// half first, and flags the clock edges at which MDC will rise or fall.
// Assumes CLK_DIV is even and at least 4. When run is low, MDC is held low
// and the phase is reset.
module mdio_mdc_gen #(
    parameter int CLK_DIV = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic rise_evt,
    output logic fall_evt
);
    localparam int HALF  = CLK_DIV / 2;
    localparam int CNT_W = $clog2(CLK_DIV);

    logic [CNT_W-1:0] cnt;

    assign rise_evt = run && (cnt == CNT_W'(HALF - 1));
    assign fall_evt = run && (cnt == CNT_W'(CLK_DIV - 1));

    // Phase counter and MDC level
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else begin
            if (fall_evt) cnt <= '0;
            else          cnt <= cnt + 1'b1;
            if (rise_evt)      mdc <= 1'b1;
            else if (fall_evt) mdc <= 1'b0;
        end
    end
endmodule

// File: rtl/mdio_frame_shifter.sv
// Module: frame sequencer. It walks the 64 bit periods of one frame, picks
// the MDIO level for each period, releases the line during the read
// turnaround and data phases, and collects the read data. Assumes rise_evt
// and fall_evt come from the MDC generator. An abort ends the frame at once.
module mdio_frame_shifter #(
    parameter int FRAME_BITS = 64,
    parameter int WORD_W     = 32,
    parameter int DATA_W     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              abort,
    input  logic [WORD_W-1:0] word_in,
    input  logic              rd_in,
    input  logic              rise_evt,
    input  logic              fall_evt,
    input  logic              mdio_i,
    output logic              busy,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic              rd_done,
    output logic [DATA_W-1:0] rd_data
);
    localparam int IDX_W    = $clog2(FRAME_BITS);
    localparam int WB_W     = $clog2(WORD_W);
    localparam int PRE_BITS = FRAME_BITS - WORD_W;
    localparam int TA_IDX   = FRAME_BITS - DATA_W - 2;
    localparam int DATA_IDX = FRAME_BITS - DATA_W;
    localparam int LAST     = FRAME_BITS - 1;

    logic [IDX_W-1:0]  idx;
    logic [IDX_W-1:0]  bitpos;
    logic [WORD_W-1:0] word_q;
    logic              rd_q;
    logic              last_fall;

    assign bitpos    = IDX_W'(LAST) - idx;
    assign last_fall = busy && fall_evt && (idx == IDX_W'(LAST));
    assign rd_done   = last_fall && rd_q && !abort;

    // MDIO level and enable for the current bit period
    always_comb begin
        mdio_oe = busy;
        if (!busy || idx < IDX_W'(PRE_BITS))
            mdio_o = 1'b1;
        else if (!rd_q && idx == IDX_W'(TA_IDX))
            mdio_o = 1'b1;
        else if (!rd_q && idx == IDX_W'(TA_IDX + 1))
            mdio_o = 1'b0;
        else
            mdio_o = word_q[bitpos[WB_W-1:0]];
        if (busy && rd_q && idx >= IDX_W'(TA_IDX)) begin
            mdio_oe = 1'b0;
            mdio_o  = 1'b1;
        end
    end

    // Frame start, period stepping, completion and abort
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            idx    <= '0;
            word_q <= '0;
            rd_q   <= 1'b0;
        end else if (abort) begin
            busy <= 1'b0;
        end else if (start) begin
            busy   <= 1'b1;
            idx    <= '0;
            word_q <= word_in;
            rd_q   <= rd_in;
        end else if (busy && fall_evt) begin
            if (last_fall) busy <= 1'b0;
            else           idx  <= idx + 1'b1;
        end
    end

    // Read data capture on MDC rising edges in the data phase
    always_ff @(posedge clk) begin
        if (!rst_n || start)
            rd_data <= '0;
        else if (busy && rise_evt && rd_q && idx >= IDX_W'(DATA_IDX))
            rd_data <= {rd_data[DATA_W-2:0], mdio_i};
    end
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
// Module: top of the MDIO management controller. It holds the command word,
// decides whether a host write is legal, starts a frame, and writes the read
// data back into the low half of the word. Assumes a synchronous active-low
// reset and a pad that resolves mdio_o/mdio_oe/mdio_i.
module mdio_mgmt_ctrl #(
    parameter int CLK_DIV = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        port_en,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output logic [31:0] mgmt_word,
    output logic        idle,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    import mdio_mgmt_pkg::*;

    logic              busy;
    logic              accept;
    logic              rd_req;
    logic              rise_evt;
    logic              fall_evt;
    logic              rd_done;
    logic [DATA_W-1:0] rd_data;

    assign idle   = !busy;
    assign rd_req = (wr_data[OP_HI -: 2] == OP_READ);
    assign accept = wr_en && port_en && !busy && word_is_legal(wr_data);

    mdio_mdc_gen #(.CLK_DIV(CLK_DIV)) mdc_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (busy && port_en),
        .mdc      (mdc),
        .rise_evt (rise_evt),
        .fall_evt (fall_evt)
    );

    mdio_frame_shifter #(
        .FRAME_BITS (FRAME_BITS),
        .WORD_W     (WORD_W),
        .DATA_W     (DATA_W)
    ) shf_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (accept),
        .abort    (!port_en),
        .word_in  (wr_data),
        .rd_in    (rd_req),
        .rise_evt (rise_evt),
        .fall_evt (fall_evt),
        .mdio_i   (mdio_i),
        .busy     (busy),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe),
        .rd_done  (rd_done),
        .rd_data  (rd_data)
    );

    // Command word: load on an accepted write, take read data at completion
    always_ff @(posedge clk) begin
        if (!rst_n)
            mgmt_word <= '0;
        else if (accept)
            mgmt_word <= wr_data;
        else if (rd_done)
            mgmt_word[DATA_W-1:0] <= rd_data;
    end
endmodule

// File: rtl/mdio_mgmt_chk.sv
// Module: property checker for the MDIO management controller, attached
// with bind. It watches only the ports of the top module.
module mdio_mgmt_chk #(
    parameter int CLK_DIV = 32
) (
    input logic        clk,
    input logic        rst_n,
    input logic        port_en,
    input logic        wr_en,
    input logic [31:0] wr_data,
    input logic [31:0] mgmt_word,
    input logic        idle,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe
);
    localparam int FRAME_CYC = 64 * CLK_DIV;
    localparam int BC_W      = $clog2(FRAME_CYC) + 2;

    logic [BC_W-1:0] busy_cnt;

    // Count the cycles spent out of idle
    always_ff @(posedge clk) begin
        if (!rst_n || idle) busy_cnt <= '0;
        else                busy_cnt <= busy_cnt + 1'b1;
    end

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> (!mdc && !mdio_oe));

    // R2
    start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && port_en && wr_en && wr_data[31:30] == 2'b01 &&
         (wr_data[29:28] == 2'b01 || wr_data[29:28] == 2'b10)) |=> !idle);

    // R6
    mdio_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mdio_o) |-> ($fell(mdc) || !$past(port_en)));

    // R7
    frame_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(idle) && $past(port_en)) |-> (busy_cnt == BC_W'(FRAME_CYC)));

    // R8
    word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle && !$past(idle)) |-> $stable(mgmt_word));

    // R9 R10
    port_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !port_en |=> (idle && !mdc));
endmodule

bind mdio_mgmt_ctrl mdio_mgmt_chk #(.CLK_DIV(CLK_DIV)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .port_en   (port_en),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .mgmt_word (mgmt_word),
    .idle      (idle),
    .mdc       (mdc),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe)
);

// File: tb/mdio_mgmt_ctrl_tb_top.sv
`timescale 1ns/1ps
module mdio_mgmt_ctrl_tb_top;
    localparam int DIV   = 32;
    localparam int HALF  = DIV / 2;
    localparam int FCYC  = 64 * DIV;
    localparam int LIMIT = FCYC + 100;

    // {command word, PHY reply}
    localparam logic [47:0] VEC [4] = '{
        {2'b01, 2'b01, 5'd3,  5'd4,  2'b10, 16'hA5C3, 16'h0000},
        {2'b01, 2'b10, 5'd31, 5'd1,  2'b00, 16'h0000, 16'h796D},
        {2'b01, 2'b01, 5'd0,  5'd31, 2'b11, 16'h0001, 16'hFFFF},
        {2'b01, 2'b10, 5'd17, 5'd16, 2'b11, 16'hBEEF, 16'h8001}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        port_en = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] mgmt_word;
    logic        idle, mdc, mdio_o, mdio_oe;
    logic        phy_mdio = 1'b1;
    logic [15:0] phy_data = '0;

    int checks = 0;
    int fails  = 0;

    logic [63:0] cap_o, cap_oe;
    int          rcnt = 0;
    logic        mdc_d = 1'b0;

    always #4 clk = ~clk;

    mdio_mgmt_ctrl #(.CLK_DIV(DIV)) dut_i (
        .clk(clk), .rst_n(rst_n), .port_en(port_en), .wr_en(wr_en),
        .wr_data(wr_data), .mgmt_word(mgmt_word), .idle(idle), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(phy_mdio)
    );

    // Bus monitor and PHY model, on falling clk edges
    always @(negedge clk) begin
        mdc_d <= mdc;
        if (idle) begin
            rcnt = 0;
        end else if (mdc && !mdc_d) begin
            if (rcnt < 64) begin
                cap_o[rcnt]  = mdio_o;
                cap_oe[rcnt] = mdio_oe;
            end
            rcnt = rcnt + 1;
        end else if (!mdc && mdc_d) begin
            if (rcnt >= 48 && rcnt <= 63) phy_mdio <= phy_data[63 - rcnt];
            else                          phy_mdio <= 1'b1;
        end
    end

    task automatic chk(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic write_word(input logic [31:0] w);
        @(negedge clk); wr_en = 1'b1; wr_data = w;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic run_frame(input logic [31:0] w, input logic [15:0] pd,
                             input bit poke);
        int  n;
        bit  rd;
        bit  ok;
        logic [31:0] alt;
        rd  = (w[29:28] == 2'b10);
        alt = {2'b01, 2'b01, 5'd9, 5'd9, 2'b10, 16'h1234};
        phy_data = pd;
        write_word(w);
        chk(idle == 1'b0, "R2 idle low after accept", 64'(idle), 64'd0);
        n = 0;
        while (!idle && n < LIMIT) begin
            @(negedge clk); n++;
            wr_en   = poke && (n == 200);
            wr_data = alt;
            if (poke && n == 202)
                chk(mgmt_word == w, "R8 word unchanged by busy write", 64'(mgmt_word), 64'(w));
        end
        wr_en = 1'b0;
        chk(n == FCYC, "R7 frame length", 64'(n), 64'(FCYC));
        chk(cap_o[31:0] == 32'hFFFFFFFF, "R3 preamble", 64'(cap_o[31:0]), 64'hFFFFFFFF);
        ok = 1'b1;
        for (int i = 32; i < 46; i++) ok &= (cap_o[i] == w[63 - i]);
        chk(ok, "R3 header bits", cap_o, 64'(w));
        if (!rd) begin
            chk(cap_o[46] == 1'b1 && cap_o[47] == 1'b0, "R4 write turnaround",
                64'(cap_o[47:46]), 64'd1);
            ok = 1'b1;
            for (int i = 48; i < 64; i++) ok &= (cap_o[i] == w[63 - i]);
            chk(ok, "R4 write data", cap_o, 64'(w[15:0]));
            chk(cap_oe == '1, "R4 oe all periods", cap_oe, '1);
            chk(mgmt_word == w, "R4 word kept after write", 64'(mgmt_word), 64'(w));
        end else begin
            chk(cap_oe[63:46] == '0 && cap_oe[45:0] == '1, "R5 read oe pattern",
                cap_oe, 64'h00003FFFFFFFFFFF);
            chk(mgmt_word == {w[31:16], pd}, "R5 read data in word",
                64'(mgmt_word), 64'({w[31:16], pd}));
        end
        chk(idle && !mdc && !mdio_oe, "R1 quiet after frame",
            64'({idle, mdc, mdio_oe}), 64'b100);
    endtask

    initial begin
        logic [31:0] prev;
        repeat (5) @(negedge clk);
        // R1 reset state
        chk(idle == 1'b1 && mdc == 1'b0 && mdio_oe == 1'b0 && mgmt_word == '0,
            "R1 reset state", 64'({idle, mdc, mdio_oe, mgmt_word}), 64'({3'b100, 32'h0}));
        rst_n = 1'b1;
        @(negedge clk);

        // Vector table walk
        for (int v = 0; v < 4; v++)
            run_frame(VEC[v][47:16], VEC[v][15:0], 1'b0);

        // R8 write during a busy frame
        run_frame(VEC[1][47:16], 16'h5AA5, 1'b1);

        // R6 MDC phase
        phy_data = '0;
        write_word(VEC[0][47:16]);
        repeat (HALF - 1) @(negedge clk);
        chk(mdc == 1'b0, "R6 mdc low first half", 64'(mdc), 64'd0);
        @(negedge clk);
        chk(mdc == 1'b1, "R6 mdc rises at half", 64'(mdc), 64'd1);
        repeat (HALF) @(negedge clk);
        chk(mdc == 1'b0, "R6 mdc falls at full period", 64'(mdc), 64'd0);
        begin
            int n = 0;
            while (!idle && n < LIMIT) begin @(negedge clk); n++; end
        end

        // R9 disabled port ignores writes
        prev = mgmt_word;
        port_en = 1'b0;
        write_word(VEC[1][47:16]);
        repeat (HALF + 2) @(negedge clk);
        chk(idle && !mdc && mgmt_word == prev, "R9 disabled write ignored",
            64'({idle, mdc, mgmt_word}), 64'({2'b10, prev}));
        port_en = 1'b1;

        // R11 illegal opcode and start code
        write_word({2'b01, 2'b11, 5'd2, 5'd2, 2'b10, 16'hCAFE});
        @(negedge clk);
        chk(idle && mgmt_word == prev, "R11 opcode 11 ignored",
            64'({idle, mgmt_word}), 64'({1'b1, prev}));
        write_word({2'b00, 2'b01, 5'd2, 5'd2, 2'b10, 16'hCAFE});
        @(negedge clk);
        chk(idle && mgmt_word == prev, "R11 start 00 ignored",
            64'({idle, mgmt_word}), 64'({1'b1, prev}));
        write_word({2'b01, 2'b00, 5'd2, 5'd2, 2'b10, 16'hCAFE});
        @(negedge clk);
        chk(idle && mgmt_word == prev, "R11 opcode 00 ignored",
            64'({idle, mgmt_word}), 64'({1'b1, prev}));

        // R10 abort by disabling mid-frame
        phy_data = 16'h1111;
        write_word(VEC[3][47:16]);
        repeat (1600) @(negedge clk);
        chk(!idle && !mdio_oe, "R10 in read data phase", 64'({idle, mdio_oe}), 64'd0);
        port_en = 1'b0;
        @(negedge clk);
        chk(idle && !mdc && !mdio_oe, "R10 abort returns to idle",
            64'({idle, mdc, mdio_oe}), 64'b100);
        port_en = 1'b1;
        @(negedge clk);
        run_frame(VEC[2][47:16], 16'h0, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule